// File: doc/BRIEF.md
# EDO DRAM Refresh and Power-Up Scheduler

This block generates all refresh traffic for an asynchronous EDO DRAM, plus the start-up traffic the memory needs. After reset it waits a programmable pause. It then issues a burst of warm-up refresh cycles and raises a ready flag. From then on it creates one refresh request per programmable interval, so that every row is refreshed within the retention period. For example, 512 rows every 8 ms gives one request about every 15.6 µs.

The scheduler drives the row strobe and the two column strobes itself. It shares the pins with an access sequencer through a request/grant pair. `req` is high whenever refresh work is owed or a refresh cycle is in flight. A new cycle only begins in a clock cycle where `grant` is high. `pins_en` marks the cycles in which this block owns the pins. The sequencer is expected to keep `grant` high while `req` is high.

Requests that arrive while the sequencer holds the bus are banked, up to a limit. They are paid back one after another once grant returns.

Two cycle kinds are supported, selected when each cycle starts:
- Column-before-row refresh, which lets the memory pick the row.
- Row-only refresh, which drives a wrapping internal row counter on `row_addr`.

Every interval is a parameter in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and right after it, `ras_n` is 1, `cas_n` is 2'b11, `req`, `pins_en` and `init_done` are 0, and `row_addr` is 0.
- R2: `req` stays 0 for the first PAUSE_CYC-1 clock edges after reset is released, and becomes 1 after edge PAUSE_CYC.
- R3: Exactly WARMUP_N refresh cycles follow the pause. `init_done` rises after edge PAUSE_CYC + WARMUP_N*(T_PRE+T_CSR+T_RAS+1) + 1 when grant is held high. It never falls again before reset, and it rises only when no cycle is active and nothing is owed.
- R4: In a column-before-row cycle, both column strobes (`cas_n` bit 1 = upper, bit 0 = lower, active low) are low for exactly T_CSR cycles before `ras_n` falls. They stay low for exactly T_CHR cycles after `ras_n` falls. `ras_n` stays low for exactly T_RAS cycles. At every `ras_n` fall the two strobe bits are equal.
- R5: Every refresh cycle opens with T_PRE owned cycles in which `ras_n` is 1 and `cas_n` is 2'b11. Before a `ras_n` fall the row strobe has therefore been high for at least T_PRE+T_CSR cycles, and before a column strobe falls the column strobes have been high for at least T_PRE cycles.
- R6: Once ready, one refresh request is generated every INTERVAL_CYC cycles. The first is generated INTERVAL_CYC edges after `init_done` rises, and each is served by exactly one refresh cycle.
- R7: Owed requests are counted up to PEND_MAX; further requests are dropped. After grant returns, the owed cycles run back to back with one idle cycle between them, and `req` then falls.
- R8: A refresh cycle starts only when `grant` was high at the starting edge. The strobes are never active while `pins_en` is 0, and `req` is high whenever `pins_en` is high.
- R9: With `mode_ras_only` = 1 when a cycle starts, the cycle holds `cas_n` at 2'b11 and `ras_n` low for T_RAS cycles, and presents `row_addr`. `row_addr` advances by one as `ras_n` rises at the end of such a cycle, wrapping from ROWS-1 to 0. Column-before-row cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ras_only | input | 1 | 1 selects row-only refresh, 0 selects column-before-row; sampled at cycle start |
| grant | input | 1 | Pins handed to this block by the access sequencer |
| req | output | 1 | Refresh work owed or in progress |
| pins_en | output | 1 | This block is driving the strobes and row address |
| init_done | output | 1 | Pause and warm-up complete; memory usable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, bit 1 upper, bit 0 lower, active low |
| row_addr | output | ROW_W | Row counter, meaningful in row-only cycles |

## Verification
Some properties are checked by assertions on every cycle:
- a cycle never starts without grant;
- every cycle begins with both strobes high;
- at a row-strobe fall, the two column strobes are equal and, when low, were already low the cycle before;
- the owed-request count never exceeds its cap;
- the row address moves only at the close of a row-only cycle;
- readiness is sticky.

Other behaviour only the bench scenarios can show. This covers the exact pause length, the warm-up count and when readiness appears, and the exact setup, hold and width counts. It also covers one refresh per interval under random grant withholding, the saturation and back-to-back drain after a long withhold, and the row counter wrap over more than 512 row-only cycles.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_RUN
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CSR,
        ST_CHR,
        ST_RASL,
        ST_ROW
    } cyc_e;

    typedef struct packed {
        logic       ras_n;
        logic [1:0] cas_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 2'b11};

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(cyc_e s);
        strobe_t p;
        p = STROBE_IDLE;
        case (s)
            ST_CSR: p.cas_n = 2'b00;
            ST_CHR: begin
                p.ras_n = 1'b0;
                p.cas_n = 2'b00;
            end
            ST_RASL, ST_ROW: p.ras_n = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CYC    = 50000,
    parameter int INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic pause_done,
    output logic tick
);
    localparam int CW = $clog2(imax(PAUSE_CYC, INTERVAL_CYC) + 1);
    localparam logic [CW-1:0] PAUSE_LD = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] INT_LD   = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          pausing_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= PAUSE_LD;
            pausing_q <= 1'b1;
        end else if (pausing_q) begin
            if (cnt_q == '0) begin
                pausing_q <= 1'b0;
                cnt_q     <= INT_LD;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (!run || cnt_q == '0) begin
            cnt_q <= INT_LD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pause_done = pausing_q && (cnt_q == '0);
    assign tick       = !pausing_q && run && (cnt_q == '0);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int MAX_PEND = 8,
    parameter int WARMUP_N = 8,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_warm,
    input  logic          tick,
    input  logic          take,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CAP  = CW'(MAX_PEND);
    localparam logic [CW-1:0] WARM = CW'(WARMUP_N);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_warm) begin
            count <= WARM;
        end else begin
            case ({tick, take})
                2'b10:   if (count < CAP) count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int ROWS  = 512,
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    generate
        if ((ROWS & (ROWS - 1)) == 0) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst)      row <= '0;
                else if (adv) row <= row + 1'b1;
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)      row <= '0;
                else if (adv) row <= (row == LAST) ? '0 : row + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
    import rfsh_pkg::*;
#(
    parameter int T_PRE = 8,
    parameter int T_CSR = 2,
    parameter int T_CHR = 3,
    parameter int T_RAS = 13
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    ras_only,
    output logic    busy,
    output logic    row_adv,
    output strobe_t pins
);
    localparam int RASL_LEN = T_RAS - T_CHR;
    localparam int CW = $clog2(imax(imax(T_PRE, T_CSR), imax(T_CHR, T_RAS)) + 1);

    cyc_e          st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          mode_q;

    function automatic logic [CW-1:0] load_for(cyc_e s);
        case (s)
            ST_PRE:  return CW'(T_PRE - 1);
            ST_CSR:  return CW'(T_CSR - 1);
            ST_CHR:  return CW'(T_CHR - 1);
            ST_RASL: return CW'(RASL_LEN - 1);
            ST_ROW:  return CW'(T_RAS - 1);
            default: return '0;
        endcase
    endfunction

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (st_q == ST_IDLE) begin
            if (start) begin
                st_d  = ST_PRE;
                cnt_d = load_for(ST_PRE);
            end
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            case (st_q)
                ST_PRE:  st_d = mode_q ? ST_ROW : ST_CSR;
                ST_CSR:  st_d = ST_CHR;
                ST_CHR:  st_d = ST_RASL;
                default: st_d = ST_IDLE;
            endcase
            cnt_d = load_for(st_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            mode_q <= 1'b0;
            pins   <= STROBE_IDLE;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == ST_IDLE && start) mode_q <= ras_only;
            pins  <= strobes_for(st_d);
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign row_adv = (st_q == ST_ROW) && (cnt_q == '0);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CYC    = 50000,
    parameter int INTERVAL_CYC = 3900,
    parameter int WARMUP_N     = 8,
    parameter int PEND_MAX     = 8,
    parameter int ROWS         = 512,
    parameter int T_PRE        = 8,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 3,
    parameter int T_RAS        = 13,
    localparam int ROW_W       = $clog2(ROWS),
    localparam int CNT_W       = $clog2(imax(PEND_MAX, WARMUP_N) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_ras_only,
    input  logic             grant,
    output logic             req,
    output logic             pins_en,
    output logic             init_done,
    output logic             ras_n,
    output logic [1:0]       cas_n,
    output logic [ROW_W-1:0] row_addr
);
    phase_e           phase_q;
    logic             pause_done;
    logic             tick;
    logic             busy;
    logic             row_adv;
    logic             start;
    logic             load_warm;
    logic [CNT_W-1:0] pend_cnt;
    strobe_t          pins;

    assign load_warm = (phase_q == PH_PAUSE) && pause_done;
    assign start     = !busy && grant && (pend_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_PAUSE;
        end else begin
            case (phase_q)
                PH_PAUSE: if (pause_done) phase_q <= PH_WARM;
                PH_WARM:  if (pend_cnt == '0 && !busy) phase_q <= PH_RUN;
                default:  ;
            endcase
        end
    end

    rfsh_timer #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (phase_q == PH_RUN),
        .pause_done(pause_done),
        .tick      (tick)
    );

    rfsh_pending #(
        .MAX_PEND(PEND_MAX),
        .WARMUP_N(WARMUP_N),
        .CW      (CNT_W)
    ) u_pend (
        .clk      (clk),
        .rst      (rst),
        .load_warm(load_warm),
        .tick     (tick),
        .take     (start),
        .count    (pend_cnt)
    );

    rfsh_cycle_fsm #(
        .T_PRE(T_PRE),
        .T_CSR(T_CSR),
        .T_CHR(T_CHR),
        .T_RAS(T_RAS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ras_only(mode_ras_only),
        .busy    (busy),
        .row_adv (row_adv),
        .pins    (pins)
    );

    rfsh_row_ctr #(
        .ROWS (ROWS),
        .ROW_W(ROW_W)
    ) u_row (
        .clk(clk),
        .rst(rst),
        .adv(row_adv),
        .row(row_addr)
    );

    assign req       = (pend_cnt != '0) || busy;
    assign pins_en   = busy;
    assign init_done = (phase_q == PH_RUN);
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
    parameter int PEND_MAX = 8,
    parameter int CNT_W    = 4,
    parameter int ROW_W    = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             grant,
    input logic             req,
    input logic             pins_en,
    input logic             init_done,
    input logic             ras_n,
    input logic [1:0]       cas_n,
    input logic [ROW_W-1:0] row_addr,
    input logic [CNT_W-1:0] pend_cnt
);

    a_r8_start_on_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_en) |-> $past(grant));

    a_r8_req_while_owned: assert property (@(posedge clk) disable iff (rst)
        pins_en |-> req);

    a_r5_open_precharged: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_en) |-> (ras_n && cas_n == 2'b11));

    a_r4_strobes_paired: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (cas_n == 2'b00 || cas_n == 2'b11));

    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && cas_n == 2'b00) |-> ($past(cas_n) == 2'b00));

    a_r7_pend_cap: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CNT_W'(PEND_MAX));

    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r3_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (!pins_en && !req));

    a_r9_row_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_addr) |-> ($rose(ras_n) && cas_n == 2'b11));

endmodule

bind dram_refresh_sched rfsh_checker #(
    .PEND_MAX(PEND_MAX),
    .CNT_W   (CNT_W),
    .ROW_W   (ROW_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .grant    (grant),
    .req      (req),
    .pins_en  (pins_en),
    .init_done(init_done),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr),
    .pend_cnt (pend_cnt)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
    localparam int P_PAUSE = 100;
    localparam int P_INT   = 100;
    localparam int P_WARM  = 8;
    localparam int P_PMAX  = 8;
    localparam int P_ROWS  = 512;
    localparam int P_PRE   = 2;
    localparam int P_CSR   = 2;
    localparam int P_CHR   = 2;
    localparam int P_RAS   = 5;
    localparam int L       = P_PRE + P_CSR + P_RAS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       grant = 1'b1;
    logic       req, pins_en, init_done, ras_n;
    logic [1:0] cas_n;
    logic [8:0] row_addr;

    dram_refresh_sched #(
        .PAUSE_CYC(P_PAUSE), .INTERVAL_CYC(P_INT), .WARMUP_N(P_WARM),
        .PEND_MAX(P_PMAX), .ROWS(P_ROWS), .T_PRE(P_PRE), .T_CSR(P_CSR),
        .T_CHR(P_CHR), .T_RAS(P_RAS)
    ) u0 (
        .clk(clk), .rst(rst), .mode_ras_only(mode), .grant(grant),
        .req(req), .pins_en(pins_en), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr)
    );

    always #2 clk = ~clk;

    int ec;
    always @(posedge clk) begin
        if (rst) ec <= 0;
        else     ec <= ec + 1;
    end

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int exp_ready_edge();
        return P_PAUSE + P_WARM * (L + 1) + 1;
    endfunction

    function automatic int next_row(input int r);
        return (r + 1) % P_ROWS;
    endfunction

    task automatic wait_ec(input int t);
        while (ec < t) @(negedge clk);
    endtask

    // pin monitor
    bit mon_on = 0;
    bit exp_rasonly = 0;
    int exp_row = 0;
    int nfall = 0;
    int last_fall_ec = 0;
    int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0;
    logic pr = 1'b1, pc = 1'b1;

    always @(negedge clk) begin
        if (mon_on) begin
            if (pr && !ras_n) begin
                nfall++;
                last_fall_ec = ec;
                if (cas_n == 2'b00) begin
                    chk(cas_lo == P_CSR, "R4 cas setup", cas_lo, P_CSR);
                    chk(ras_hi >= P_PRE + P_CSR, "R5 ras precharge", ras_hi, P_PRE + P_CSR);
                    chk(!exp_rasonly, "R9 cycle kind", 0, 1);
                end else begin
                    chk(cas_n == 2'b11 && exp_rasonly, "R9 cas high in row cycle", cas_n, 3);
                    chk(row_addr == exp_row, "R9 row address", row_addr, exp_row);
                    exp_row = next_row(exp_row);
                end
            end
            if (!pr && ras_n)
                chk(ras_lo == P_RAS, "R4 ras width", ras_lo, P_RAS);
            if (!pc && cas_n[0] && !ras_n)
                chk(ras_lo == P_CHR, "R4 cas hold", ras_lo, P_CHR);
            if (pc && !cas_n[0])
                chk(cas_hi >= P_PRE, "R5 cas precharge", cas_hi, P_PRE);
            if (!ras_n || cas_n != 2'b11)
                chk(pins_en == 1'b1, "R8 pins owned", pins_en, 1);
            if (cas_n[0] != cas_n[1])
                chk(0, "R4 strobes equal", cas_n, 0);
            ras_hi = ras_n ? ras_hi + 1 : 0;
            ras_lo = !ras_n ? ras_lo + 1 : 0;
            cas_hi = cas_n[0] ? cas_hi + 1 : 0;
            cas_lo = !cas_n[0] ? cas_lo + 1 : 0;
            pr = ras_n;
            pc = cas_n[0];
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", ec, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int r_edge, t0, t1, t2, n0, d;
        void'($urandom(32'd4051));
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
        chk(cas_n == 2'b11, "R1 cas_n", cas_n, 3);
        chk(req == 1'b0, "R1 req", req, 0);
        chk(pins_en == 1'b0, "R1 pins_en", pins_en, 0);
        chk(init_done == 1'b0, "R1 init_done", init_done, 0);
        chk(row_addr == 0, "R1 row_addr", row_addr, 0);
        rst = 1'b0;
        mon_on = 1;

        // R2 pause
        wait_ec(P_PAUSE - 1);
        chk(req == 1'b0, "R2 quiet during pause", req, 0);
        @(negedge clk);
        chk(req == 1'b1, "R2 warm-up request after pause", req, 1);

        // R3 warm-up and readiness
        r_edge = exp_ready_edge();
        wait_ec(r_edge - 1);
        chk(init_done == 1'b0, "R3 not ready early", init_done, 0);
        @(negedge clk);
        chk(init_done == 1'b1, "R3 ready edge", init_done, 1);
        chk(nfall == P_WARM, "R3 warm-up count", nfall, P_WARM);
        chk(row_addr == 0, "R9 unchanged by column-first cycles", row_addr, 0);

        // R6 / R8 random grant withholding, one refresh per interval
        for (int k = 1; k <= 20; k++) begin
            wait_ec(r_edge + k * P_INT);
            grant = 1'b0;
            n0 = nfall;
            d = $urandom_range(50, 0);
            repeat (d) @(negedge clk);
            chk(nfall == n0, "R8 no cycle while grant low", nfall - n0, 0);
            grant = 1'b1;
            wait_ec(r_edge + (k + 1) * P_INT - 1);
            chk(nfall - n0 == 1, "R6 one refresh per interval", nfall - n0, 1);
        end

        // R7 saturation and back-to-back drain
        t0 = r_edge + 21 * P_INT;
        wait_ec(t0);
        grant = 1'b0;
        t1 = t0 + 11 * P_INT;
        wait_ec(t1);
        chk(req == 1'b1, "R7 owed while withheld", req, 1);
        n0 = nfall;
        grant = 1'b1;
        wait_ec(t1 + 95);
        chk(nfall - n0 == P_PMAX, "R7 capped count", nfall - n0, P_PMAX);
        chk(req == 1'b0, "R7 drained", req, 0);
        chk(last_fall_ec == t1 + 1 + P_PRE + P_CSR + (P_PMAX - 1) * (L + 1),
            "R7 back to back", last_fall_ec,
            t1 + 1 + P_PRE + P_CSR + (P_PMAX - 1) * (L + 1));

        // R9 row-only mode across the wrap
        t2 = t1 + P_INT;
        wait_ec(t2);
        mode = 1'b1;
        exp_rasonly = 1;
        n0 = nfall;
        wait_ec(t2 + 515 * P_INT);
        chk(nfall - n0 == 515, "R9 row-only cycles", nfall - n0, 515);
        chk(row_addr == 3, "R9 wrap", row_addr, 3);
        chk(init_done == 1'b1, "R3 ready stays", init_done, 1);

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule